// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Master

This block starts single-word read and write transactions on a fully interlocked asynchronous bus. A local agent pulses a start strobe with an address, a direction flag and, for writes, a data word. The controller registers the command and drives it onto the bus. It waits a fixed number of clock cycles so that every slave has time to decode the address, and only then raises its request line. It holds the request until the acknowledge line comes back high. It then drops the request, latching read data at that instant, and waits for the acknowledge to return to zero. After that it reports completion with a one-cycle done pulse.

The acknowledge line comes from another timing domain, so it passes through a two-stage synchronizer before the controller acts on it. A synthesizable slave model sits beside the controller. It has a small register store selected by the upper address bits, a programmable response latency and its own request synchronizer. Connecting the two shows the complete return-to-zero exchange end to end.

Top module: `hsk_master`

## Requirements
- R1: While reset is held and right after it is released, the request, done, bus address, bus write flag, bus data out and read data outputs are all zero.
- R2: A start seen while the controller is idle is taken at that clock edge. From the next cycle on, the bus shows the command's address, its direction (bus write flag 1 = write, 0 = read) and its write data.
- R3: The request stays low while the address is being decoded. It rises exactly DECODE_CYC clock edges after the edge at which the address was first driven.
- R4: The request stays high until the acknowledge is seen high. Because of the two-stage synchronizer, it falls at the third rising edge after the acknowledge input rises.
- R5: On a read, the read data output takes the value of the bus data input at the edge where the request falls. Later changes on the bus data input do not alter it. A write leaves the read data output unchanged.
- R6: Done rises at the third rising edge after the acknowledge input falls, never earlier, and stays high for exactly one cycle.
- R7: A start given while a transaction is in progress is ignored. The bus address stays as it was, and no further request follows the done pulse.
- R8: The bus address, data out and write flag do not change from the cycle they are driven until the acknowledge has been released.
- R9: A start given in the cycle that done is high is accepted, so the next address appears on the bus in the following cycle.
- R10: The slave model stores write data at entry (address mod DEPTH) and answers a read of the same entry with that data. Only addresses whose upper bits match its base are selected.
- R11: The slave model raises acknowledge only while the request is high. It keeps acknowledge high until it has seen the request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start_i | input | 1 | Start strobe for a new transaction |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | ADDR_W | Transaction address |
| cmd_wdata_i | input | DATA_W | Write data |
| cmd_done_o | output | 1 | One-cycle completion pulse |
| cmd_rdata_o | output | DATA_W | Data captured by the last read |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_write_o | output | 1 | Bus direction, 1 = write |
| bus_dout_o | output | DATA_W | Bus write data |
| bus_din_i | input | DATA_W | Bus read data from the slave |
| bus_req_o | output | 1 | Request line |
| bus_ack_i | input | 1 | Acknowledge line from the slave |

## Verification
A write is run against a bench-driven acknowledge with exact edge counting. This separates a correct decode wait and synchronizer latency from an off-by-one in either, and from a done that fires before the acknowledge has returned to zero. A read is run in which the bus data changes right after the request falls, which shows whether the sample point is right. A start pulse during the decode wait and a start during the done cycle distinguish a command that is ignored from one that is queued or lost. Reads and writes through the slave model at several entries confirm the full return-to-zero exchange and the stored data.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        M_IDLE,
        M_SETUP,
        M_REQ,
        M_REL
    } mst_state_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_HOLD
    } slv_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_cmd_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/hsk_sync2.sv
module hsk_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/hsk_decode_timer.sv
module hsk_decode_timer
    import hsk_pkg::*;
#(
    parameter int CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic fire
);
    localparam int W = cnt_w(CYC);
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    logic         armed;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed) begin
            if (cnt == LAST) armed <= 1'b0;
            else             cnt   <= cnt + 1'b1;
        end
    end

    assign fire = armed && (cnt == LAST);
endmodule

// File: rtl/hsk_slave_model.sv
module hsk_slave_model
    import hsk_pkg::*;
#(
    parameter int                RESP_CYC = 2,
    parameter int                DEPTH    = 16,
    parameter logic [ADDR_W-1:0] BASE     = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              ack_o
);
    localparam int IDX_W = cnt_w(DEPTH);
    localparam int CW    = cnt_w(RESP_CYC);
    localparam logic [CW-1:0] LAST = CW'(RESP_CYC - 1);

    slv_state_e        st;
    logic [CW-1:0]     cnt;
    logic              req_s;
    logic              sel;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mem [DEPTH];

    hsk_sync2 #(.STAGES(2)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_i),
        .q   (req_s)
    );

    assign idx = addr_i[IDX_W-1:0];
    assign sel = (addr_i[ADDR_W-1:IDX_W] == BASE[ADDR_W-1:IDX_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            ack_o  <= 1'b0;
            dout_o <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_s && sel) begin
                        cnt <= '0;
                        st  <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (cnt == LAST) begin
                        if (write_i) mem[idx] <= din_i;
                        else         dout_o   <= mem[idx];
                        ack_o <= 1'b1;
                        st    <= S_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_HOLD: begin
                    if (!req_s) begin
                        ack_o <= 1'b0;
                        st    <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hsk_master.sv
module hsk_master
    import hsk_pkg::*;
#(
    parameter int DECODE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start_i,
    input  logic              cmd_write_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    output logic              cmd_done_o,
    output logic [DATA_W-1:0] cmd_rdata_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_write_o,
    output logic [DATA_W-1:0] bus_dout_o,
    input  logic [DATA_W-1:0] bus_din_i,
    output logic              bus_req_o,
    input  logic              bus_ack_i
);
    mst_state_e st;
    bus_cmd_t   cmd_q;
    logic       ack_s;
    logic       launch;
    logic       setup_done;

    hsk_sync2 #(.STAGES(2)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_ack_i),
        .q   (ack_s)
    );

    assign launch = (st == M_IDLE) && cmd_start_i;

    hsk_decode_timer #(.CYC(DECODE_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .arm  (launch),
        .fire (setup_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= M_IDLE;
            cmd_q       <= '0;
            bus_req_o   <= 1'b0;
            cmd_done_o  <= 1'b0;
            cmd_rdata_o <= '0;
        end else begin
            cmd_done_o <= 1'b0;
            case (st)
                M_IDLE: begin
                    if (cmd_start_i) begin
                        cmd_q.write <= cmd_write_i;
                        cmd_q.addr  <= cmd_addr_i;
                        cmd_q.data  <= cmd_wdata_i;
                        st          <= M_SETUP;
                    end
                end
                M_SETUP: begin
                    if (setup_done) begin
                        bus_req_o <= 1'b1;
                        st        <= M_REQ;
                    end
                end
                M_REQ: begin
                    if (ack_s) begin
                        bus_req_o <= 1'b0;
                        if (!cmd_q.write) cmd_rdata_o <= bus_din_i;
                        st <= M_REL;
                    end
                end
                M_REL: begin
                    if (!ack_s) begin
                        cmd_done_o <= 1'b1;
                        st         <= M_IDLE;
                    end
                end
                default: st <= M_IDLE;
            endcase
        end
    end

    assign bus_addr_o  = cmd_q.addr;
    assign bus_write_o = cmd_q.write;
    assign bus_dout_o  = cmd_q.data;
endmodule

// File: rtl/hsk_master_chk.sv
module hsk_master_chk
    import hsk_pkg::*;
#(
    parameter int DECODE_CYC = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              launch,
    input logic              req,
    input logic              ack,
    input logic              done,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic              write
);
    logic [15:0] gap;

    always_ff @(posedge clk) begin
        if (rst)                gap <= '0;
        else if (launch)        gap <= '0;
        else if (gap != 16'hFFFF) gap <= gap + 1'b1;
    end

    a_r3_decode_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> (gap == 16'(DECODE_CYC)));

    a_r4_req_falls_with_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> ack);

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_done_after_release: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ack && !req));

    a_r8_bus_stable: assert property (@(posedge clk) disable iff (rst)
        (req || ack) |-> ($stable(addr) && $stable(dout) && $stable(write)));
endmodule

module hsk_slave_chk (
    input logic clk,
    input logic rst,
    input logic req,
    input logic ack
);
    a_r11_ack_rises_on_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> req);

    a_r11_ack_held_until_release: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !req);
endmodule

bind hsk_master hsk_master_chk #(.DECODE_CYC(DECODE_CYC)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .req    (bus_req_o),
    .ack    (bus_ack_i),
    .done   (cmd_done_o),
    .addr   (bus_addr_o),
    .dout   (bus_dout_o),
    .write  (bus_write_o)
);

bind hsk_slave_model hsk_slave_chk u_schk (
    .clk (clk),
    .rst (rst),
    .req (req_i),
    .ack (ack_o)
);

// File: tb/sim_hsk_master.sv
`timescale 1ns/1ps
module sim_hsk_master;
    import hsk_pkg::*;

    localparam int DLY = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              done;
    logic [DATA_W-1:0] rdata;
    logic [ADDR_W-1:0] b_addr;
    logic              b_wr;
    logic [DATA_W-1:0] b_dout;
    logic [DATA_W-1:0] b_din;
    logic              b_req;
    logic              b_ack;

    logic              use_model = 1'b0;
    logic              tb_ack = 1'b0;
    logic [DATA_W-1:0] tb_din = '0;
    logic [DATA_W-1:0] m_dout;
    logic              m_ack;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    assign b_ack = use_model ? m_ack  : tb_ack;
    assign b_din = use_model ? m_dout : tb_din;

    hsk_master #(.DECODE_CYC(DLY)) u0 (
        .clk (clk), .rst (rst),
        .cmd_start_i (start), .cmd_write_i (wr),
        .cmd_addr_i (addr), .cmd_wdata_i (wdata),
        .cmd_done_o (done), .cmd_rdata_o (rdata),
        .bus_addr_o (b_addr), .bus_write_o (b_wr),
        .bus_dout_o (b_dout), .bus_din_i (b_din),
        .bus_req_o (b_req), .bus_ack_i (b_ack)
    );

    hsk_slave_model #(.RESP_CYC(2), .DEPTH(16), .BASE('0)) u_slv (
        .clk (clk), .rst (rst),
        .req_i (b_req & use_model), .write_i (b_wr),
        .addr_i (b_addr), .din_i (b_dout),
        .dout_o (m_dout), .ack_o (m_ack)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        start = 1'b1; wr = w; addr = a; wdata = d;
        tick();
        start = 1'b0; addr = ~a; wdata = ~d; wr = ~w;
    endtask

    // handshake from the cycle after launch, bench acting as slave
    task automatic complete(input logic w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic [DATA_W-1:0] rpat, input logic poke,
                            input logic b2b, input logic [ADDR_W-1:0] nb);
        logic [DATA_W-1:0] rd_before;
        rd_before = rdata;
        chk("R2 bus address", 32'(b_addr), 32'(a));
        chk("R2 bus write flag", 32'(b_wr), 32'(w));
        chk("R2 bus data out", b_dout, d);
        chk("R3 req low at launch", 32'(b_req), 32'd0);
        for (int i = 1; i < DLY; i++) begin
            if (poke && i == 1) begin
                start = 1'b1; addr = a ^ 16'h00F0; wr = ~w;
            end
            tick();
            start = 1'b0;
            chk("R3 req low during decode", 32'(b_req), 32'd0);
            if (poke) chk("R7 address kept while busy", 32'(b_addr), 32'(a));
        end
        tick();
        chk("R3 req high after decode", 32'(b_req), 32'd1);
        repeat (4) tick();
        chk("R4 req held without ack", 32'(b_req), 32'd1);
        tb_din = rpat; tb_ack = 1'b1;
        tick(); tick();
        chk("R4 req still high two edges after ack", 32'(b_req), 32'd1);
        tick();
        chk("R4 req falls third edge after ack", 32'(b_req), 32'd0);
        tb_din = ~rpat;
        tick();
        chk("R6 no done while ack high", 32'(done), 32'd0);
        chk("R8 address stable until release", 32'(b_addr), 32'(a));
        chk("R8 data stable until release", b_dout, d);
        tb_ack = 1'b0;
        tick(); tick();
        chk("R6 done not early", 32'(done), 32'd0);
        tick();
        chk("R6 done on third edge after release", 32'(done), 32'd1);
        if (!w) chk("R5 read data sampled at req fall", rdata, rpat);
        else    chk("R5 write keeps read data", rdata, rd_before);
        if (b2b) begin
            start = 1'b1; wr = 1'b1; addr = nb; wdata = 32'hB2B0_0000 | 32'(nb);
        end
        tick();
        start = 1'b0;
        chk("R6 done one cycle", 32'(done), 32'd0);
        if (b2b) chk("R9 start in done cycle accepted", 32'(b_addr), 32'(nb));
    endtask

    task automatic model_txn(input logic w, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] q);
        int n;
        launch(w, a, d);
        n = 0;
        while (!done && n < 200) begin
            tick();
            n++;
        end
        chk("R11 model transaction completes", 32'(done), 32'd1);
        chk("R11 ack released at done", 32'(b_ack), 32'd0);
        q = rdata;
        tick();
    endtask

    task automatic t_reset();
        repeat (2) tick();
        chk("R1 req in reset", 32'(b_req), 32'd0);
        chk("R1 done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        tick();
        chk("R1 addr after reset", 32'(b_addr), 32'd0);
        chk("R1 write flag after reset", 32'(b_wr), 32'd0);
        chk("R1 data out after reset", b_dout, 32'd0);
        chk("R1 read data after reset", rdata, 32'd0);
        chk("R1 req after reset", 32'(b_req), 32'd0);
    endtask

    task automatic t_write();
        launch(1'b1, 16'h1234, 32'hCAFE_0001);
        complete(1'b1, 16'h1234, 32'hCAFE_0001, 32'h0BAD_0BAD, 1'b0, 1'b0, '0);
    endtask

    task automatic t_read();
        launch(1'b0, 16'h0042, 32'h1111_2222);
        complete(1'b0, 16'h0042, 32'h1111_2222, 32'h5A5A_C3C3, 1'b0, 1'b0, '0);
    endtask

    task automatic t_busy();
        launch(1'b1, 16'h0300, 32'h0000_0300);
        complete(1'b1, 16'h0300, 32'h0000_0300, 32'h0, 1'b1, 1'b0, '0);
        repeat (8) begin
            tick();
            chk("R7 no request after ignored start", 32'(b_req), 32'd0);
        end
        chk("R7 address unchanged", 32'(b_addr), 32'h0300);
    endtask

    task automatic t_back_to_back();
        launch(1'b0, 16'h0A0A, 32'h0);
        complete(1'b0, 16'h0A0A, 32'h0, 32'h7777_8888, 1'b0, 1'b1, 16'h0B0B);
        // the second transaction was launched one edge ago
        complete(1'b1, 16'h0B0B, 32'hB2B0_0B0B, 32'h0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_model();
        logic [DATA_W-1:0] q;
        use_model = 1'b1;
        model_txn(1'b1, 16'h0003, 32'hDEAD_0003, q);
        model_txn(1'b1, 16'h000C, 32'hBEEF_000C, q);
        model_txn(1'b1, 16'h0003, 32'h1357_9BDF, q);
        model_txn(1'b0, 16'h000C, 32'h0, q);
        chk("R10 read back entry 12", q, 32'hBEEF_000C);
        model_txn(1'b0, 16'h0003, 32'h0, q);
        chk("R10 read back overwritten entry 3", q, 32'h1357_9BDF);
        model_txn(1'b0, 16'h0005, 32'h0, q);
        chk("R10 unwritten entry reads zero", q, 32'h0);
        use_model = 1'b0;
    endtask

    initial begin
        t_reset();
        t_write();
        t_read();
        t_busy();
        t_back_to_back();
        t_model();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule